// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block supervises a system that may be running its clocks above a safe rate. While armed, it counts whole seconds derived from a reference tick. If software does not service it with a kick strobe before the programmed number of seconds has passed, the block trips. A trip does three things. It swaps the frequency-select code it passes on for a stored safe code. It sets a sticky status flag. It asserts a fixed-width enable that pulls an open-drain, active-low system reset line low.

The surrounding logic supplies a reference tick enable (one pulse per reference period, nominally 14.318 MHz), the enable bit, the timeout in seconds, the safe code and the normal code. A configuration register outside this block normally resets the timeout to 16 seconds and the enable, status and safe code to zero. The reset line is never driven high. The output `rst_pull_low` only switches on the pull-down device, and an external resistor pulls the line back up.

Top module: `freq_watchdog`

## Requirements
- R1: After reset, `rst_pull_low`, `override` and `status` are 0 and `freq_sel` equals `norm_sel`.
- R2: With `wd_en`=1, a nonzero `timeout_sec`=T, `ref_tick` high on every cycle and no kick, `rst_pull_low` first reads 1 after rising edge number 1+T·REF_HZ. Edge 1 is the edge that first samples the block armed.
- R3: From the trip edge on, `override`=1 and `freq_sel`=`safe_sel`. Kicks do not change this. One edge after `wd_en` is sampled low or `timeout_sec` is sampled 0, `override` is 0 and `freq_sel`=`norm_sel` again.
- R4: `rst_pull_low` is a pull-down enable that is 1 for exactly REF_HZ·32/1000 reference ticks after the trip edge. With `ref_tick` high on every cycle and REF_HZ=1000, that is 32 cycles. The pulse runs to full length even if the watchdog is disabled during it.
- R5: `status` becomes 1 on the trip edge and stays 1 until `status_clr` is sampled high.
- R6: A kick sampled at edge k while counting restarts the count. Without further kicks, the trip edge is k+T·REF_HZ.
- R7: A `timeout_sec` of 0 counts as disabled: no trip, no reset pulse and no status, however long `wd_en` stays high.
- R8: Disabling the watchdog clears the count. Re-enabling it starts a full T-second timeout, timed as in R2.
- R9: One second is REF_HZ pulses of `ref_tick`, and the reset width is also counted in `ref_tick` pulses. With a tick on every second cycle, the pulse lasts 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One pulse per reference-clock period |
| wd_en | input | 1 | Watchdog enable bit |
| timeout_sec | input | TO_W | Timeout in seconds, 0 = disabled |
| kick | input | 1 | Service strobe from software |
| status_clr | input | 1 | Clears the trip status flag |
| norm_sel | input | SEL_W | Frequency select used while not tripped |
| safe_sel | input | SEL_W | Safe frequency select applied on trip |
| freq_sel | output | SEL_W | Frequency select passed to the synthesizer |
| override | output | 1 | 1 while the safe code is forced |
| status | output | 1 | Sticky trip flag |
| rst_pull_low | output | 1 | Pull-down enable for the open-drain reset line |

## Verification
On every cycle, assertions check the following. The safe override holds while the block stays armed. A kick never trips in the same step. A zero timeout or a dropped enable returns the block to idle. Status stays set until it is cleared. Each reset pulse starts together with a new trip. Only the bench scenarios can show the absolute cycle at which a trip lands after arming, after a kick and after re-enabling. They also show the exact pulse width at both tick rates, and that no pulse appears under a zero timeout or regular kicking.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;
endpackage

// File: rtl/fwd_sec_tick.sv
// Divides the reference tick down to one pulse per second while counting.
module fwd_sec_tick #(
  parameter int SEC_DIV = 14318180
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic ref_tick,
  output logic sec_pulse
);
  localparam int CNT_W = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEC_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en    = !run || restart || ref_tick;
  assign sec_pulse = run && !restart && ref_tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || restart)    cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fwd_timeout_ctl.sv
// Seconds counter and idle/run/trip control.
module fwd_timeout_ctl
  import fwd_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wd_en,
  input  logic [TO_W-1:0] timeout_sec,
  input  logic            kick,
  input  logic            sec_pulse,
  output logic            run,
  output logic            restart,
  output logic            expire,
  output logic            tripped
);
  wd_state_e       state_q, state_d;
  logic [TO_W-1:0] elapsed_q, elapsed_d;
  logic [TO_W:0]   elapsed_inc;
  logic            armed;

  assign armed       = wd_en && (timeout_sec != '0);
  assign elapsed_inc = {1'b0, elapsed_q} + (TO_W+1)'(1);
  assign run         = (state_q == WD_RUN);
  assign restart     = kick || !armed;
  assign expire      = run && armed && !kick && sec_pulse &&
                       (elapsed_inc >= {1'b0, timeout_sec});
  assign tripped     = (state_q == WD_TRIP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      WD_IDLE: if (armed) state_d = WD_RUN;
      WD_RUN: begin
        if (!armed)      state_d = WD_IDLE;
        else if (expire) state_d = WD_TRIP;
      end
      WD_TRIP: if (!armed) state_d = WD_IDLE;
      default: state_d = WD_IDLE;
    endcase
  end

  always_comb begin
    elapsed_d = elapsed_q;
    if (!run || restart || expire) elapsed_d = '0;
    else if (sec_pulse)            elapsed_d = elapsed_inc[TO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WD_IDLE;
      elapsed_q <= '0;
    end else begin
      state_q   <= state_d;
      elapsed_q <= elapsed_d;
    end
  end

  // R3: the safe override stays while the block remains armed
  assert_override_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && wd_en && (timeout_sec != '0)) |=> tripped);
  // R6: a serviced step never trips
  assert_kick_no_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick) |=> !tripped);
  // R7, R8: zero timeout or disable returns to idle
  assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en || (timeout_sec == '0)) |=> (!run && !tripped));
endmodule

// File: rtl/fwd_rst_pulse.sv
// Fixed-width pull-down pulse counted in reference ticks.
module fwd_rst_pulse #(
  parameter int PULSE_DIV = 458181
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ref_tick,
  output logic pull_low
);
  localparam int CNT_W = $clog2(PULSE_DIV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign pull_low = (cnt_q != '0);
  assign cnt_en   = start || (ref_tick && pull_low);

  always_comb begin
    if (start) cnt_d = CNT_W'(PULSE_DIV);
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog #(
  parameter int REF_HZ   = 14318180,
  parameter int PULSE_MS = 32,
  parameter int TO_W     = 8,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             wd_en,
  input  logic [TO_W-1:0]  timeout_sec,
  input  logic             kick,
  input  logic             status_clr,
  input  logic [SEL_W-1:0] norm_sel,
  input  logic [SEL_W-1:0] safe_sel,
  output logic [SEL_W-1:0] freq_sel,
  output logic             override,
  output logic             status,
  output logic             rst_pull_low
);
  localparam longint PULSE_RAW = (longint'(REF_HZ) * PULSE_MS) / 1000;
  localparam int     PULSE_DIV = (PULSE_RAW < 1) ? 1 : int'(PULSE_RAW);

  logic sec_pulse, run, restart, expire, tripped;
  logic status_q, status_d;

  fwd_sec_tick #(.SEC_DIV(REF_HZ)) u_sec (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .ref_tick(ref_tick), .sec_pulse(sec_pulse)
  );

  fwd_timeout_ctl #(.TO_W(TO_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .timeout_sec(timeout_sec),
    .kick(kick), .sec_pulse(sec_pulse), .run(run), .restart(restart),
    .expire(expire), .tripped(tripped)
  );

  fwd_rst_pulse #(.PULSE_DIV(PULSE_DIV)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(expire), .ref_tick(ref_tick),
    .pull_low(rst_pull_low)
  );

  always_comb begin
    status_d = status_q;
    if (expire)          status_d = 1'b1;
    else if (status_clr) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status   = status_q;
  assign override = tripped;
  assign freq_sel = tripped ? safe_sel : norm_sel;

  // R5: status only drops on a clear request
  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !status_clr) |=> status);
  // R4: every reset pulse begins together with a fresh trip
  assert_pulse_on_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pull_low) |-> ($rose(override) && status));
endmodule

// File: tb/test_freq_watchdog.sv
module test_freq_watchdog;
  localparam int REF_HZ = 1000;
  localparam int PW     = 32;

  typedef struct {
    int    rise;
    int    width;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n, ref_tick, wd_en, kick, status_clr;
  logic [7:0] timeout_sec;
  logic [3:0] norm_sel, safe_sel, freq_sel;
  logic       override, status, rst_pull_low;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   slow_ref = 1'b0;
  bit   done = 1'b0;
  exp_t expq[$];

  freq_watchdog #(.REF_HZ(REF_HZ), .PULSE_MS(32), .TO_W(8), .SEL_W(4)) i_freq_watchdog (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wd_en(wd_en),
    .timeout_sec(timeout_sec), .kick(kick), .status_clr(status_clr),
    .norm_sel(norm_sel), .safe_sel(safe_sel), .freq_sel(freq_sel),
    .override(override), .status(status), .rst_pull_low(rst_pull_low)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    ref_tick = 1'b1;
    forever begin
      @(negedge clk);
      ref_tick = slow_ref ? ~ref_tick : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_pulse(input int rise, input int width, input string req);
    exp_t e;
    e.rise = rise; e.width = width; e.req = req;
    expq.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick_once();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Monitor: measures each reset pulse and compares with the scoreboard
  int  rise_at = 0;
  int  hi_len = 0;
  bit  prev = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rst_pull_low && !prev) begin
          rise_at = cyc;
          hi_len  = 0;
        end
        if (rst_pull_low) hi_len++;
        if (!rst_pull_low && prev) begin
          if (expq.size() == 0) begin
            check(1'b0, "R7 unexpected reset pulse", rise_at, -1);
          end else begin
            exp_t e;
            e = expq.pop_front();
            if (e.rise >= 0) check(rise_at == e.rise, e.req, rise_at, e.rise);
            check(hi_len == e.width, {e.req, " width R4"}, hi_len, e.width);
          end
        end
        prev = rst_pull_low;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; wd_en = 1'b0; kick = 1'b0; status_clr = 1'b0;
    timeout_sec = 8'h10; norm_sel = 4'd3; safe_sel = 4'd9;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    check(rst_pull_low == 1'b0, "R1 reset pull", rst_pull_low, 0);
    check(override == 1'b0, "R1 reset override", override, 0);
    check(status == 1'b0, "R1 reset status", status, 0);
    check(freq_sel == norm_sel, "R1 reset freq_sel", freq_sel, norm_sel);

    // R2/R3/R5: plain expiry after two seconds
    timeout_sec = 8'd2;
    c = cyc;
    wd_en = 1'b1;
    expect_pulse(c + 1 + 2 * REF_HZ, PW, "R2 expiry timing");
    wait_cyc(2 * REF_HZ + PW + 10);
    check(status == 1'b1, "R5 status set", status, 1);
    check(override == 1'b1, "R3 override set", override, 1);
    check(freq_sel == 4'd9, "R3 safe code", freq_sel, 9);

    // R5: clear status, override stays
    status_clr = 1'b1;
    wait_cyc(1);
    status_clr = 1'b0;
    check(status == 1'b0, "R5 status cleared", status, 0);
    check(override == 1'b1, "R3 override after clear", override, 1);

    // R3: kick while tripped is ignored
    kick_once();
    wait_cyc(5);
    check(freq_sel == 4'd9, "R3 kick ignored", freq_sel, 9);

    // R3: disable restores normal code one edge later
    wd_en = 1'b0;
    wait_cyc(1);
    check(override == 1'b0, "R3 override released", override, 0);
    check(freq_sel == 4'd3, "R3 normal code back", freq_sel, 3);

    // R6: regular kicks hold it off, last kick times the trip
    timeout_sec = 8'd1;
    wd_en = 1'b1;
    wait_cyc(2);
    for (int i = 0; i < 5; i++) begin
      wait_cyc(700);
      c = cyc;
      kick_once();
    end
    check(status == 1'b0, "R6 no trip while kicked", status, 0);
    expect_pulse(c + 1 + REF_HZ, PW, "R6 trip after last kick");
    wait_cyc(REF_HZ + PW + 10);
    check(status == 1'b1, "R6 trip seen", status, 1);
    wd_en = 1'b0;
    status_clr = 1'b1;
    wait_cyc(1);
    status_clr = 1'b0;

    // R7: zero timeout never trips
    timeout_sec = 8'd0;
    wd_en = 1'b1;
    wait_cyc(3 * REF_HZ);
    check(status == 1'b0, "R7 zero timeout status", status, 0);
    check(override == 1'b0, "R7 zero timeout override", override, 0);
    wd_en = 1'b0;
    wait_cyc(2);

    // R8: disable mid-count restarts; R4: pulse outlives a disable
    timeout_sec = 8'd1;
    wd_en = 1'b1;
    wait_cyc(600);
    wd_en = 1'b0;
    wait_cyc(1);
    c = cyc;
    wd_en = 1'b1;
    expect_pulse(c + 1 + REF_HZ, PW, "R8 restart after disable");
    wait_cyc(REF_HZ + 6);
    check(rst_pull_low == 1'b1, "R4 pulse active", rst_pull_low, 1);
    wd_en = 1'b0;
    wait_cyc(1);
    check(freq_sel == 4'd3, "R3 normal code during pulse", freq_sel, 3);
    wait_cyc(PW + 10);
    status_clr = 1'b1;
    wait_cyc(1);
    status_clr = 1'b0;

    // R9: half-rate reference tick doubles the pulse width
    slow_ref = 1'b1;
    wait_cyc(2);
    wd_en = 1'b1;
    expect_pulse(-1, 2 * PW, "R9 slow reference");
    wait_cyc(2 * REF_HZ + 2 * PW + 20);
    check(status == 1'b1, "R9 slow trip", status, 1);
    wd_en = 1'b0;
    slow_ref = 1'b0;
    wait_cyc(5);

    check(expq.size() == 0, "R2 all expected pulses seen", expq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule